// File: doc/BRIEF.md
# SPI master shift engine

This block is the serial engine of an SPI master. A start request latches a transmit word and the transfer settings: length, the SCLK edges used to launch and to capture data, bit order, idle clock level and clock divider. The engine then runs a single transaction on SCLK, MOSI and MISO. When the last clock edge has been produced, it returns the received word together with a one-cycle done pulse.

Two slave-select lines are driven from a 2-bit mask. They either follow the mask directly or are asserted only while a transaction runs. Their active level can be set. A sticky completion flag, cleared by a write-one strobe, raises the interrupt line when interrupts are enabled. A stop request aborts a running transaction. The register interface around the engine is not part of this block.

Top module: `spi_master_engine`

## Requirements
- R1: After reset, busy, done_pulse, done_flag, irq and mosi are 0, and SCLK sits at the level given by cpol.
- R2: A length code n from 1 to 31 moves n bits, and code 0 moves 32 bits. A transaction produces exactly 2·L SCLK edges, where L is the bit count.
- R3: Every SCLK half-period lasts divider+1 clock cycles, counted from the cycle in which start is accepted. A divider of 0 gives a half-period of one cycle, which is the fastest rate.
- R4: While idle, SCLK rests at cpol (0 low, 1 high). It is back at that level in the cycle where the transaction ends.
- R5: The first data bit is on MOSI from the cycle after start is accepted. MOSI moves to the next bit on every SCLK edge whose direction matches tx_fall (0 rising, 1 falling). MOSI is 0 when idle and once all bits have been sent.
- R6: On every SCLK edge whose direction matches rx_fall (0 rising, 1 falling), MISO is sampled at the clock edge where SCLK changes.
- R7: With lsb_first=1, bit 0 of the transmit word is sent first and the first received bit goes to bit 0. Otherwise bit L-1 is first in both directions.
- R8: rx_word is zero above bit L-1, is valid in the cycle done_pulse is high, and holds that value until the next start.
- R9: start while idle begins a transaction. busy stays 1 until it ends and then clears, with done_pulse high for that one cycle. start while busy is ignored, and the settings are taken only at start.
- R10: stop while busy ends the transaction on the next edge. SCLK returns to idle and no done pulse or done flag is produced.
- R11: With auto_sel=1, the lines set in sel_mask are active only while busy. With auto_sel=0, sel_mask drives the lines directly. sel_active_high picks the active level (0 low, 1 high).
- R12: done_flag sets with done_pulse and stays set until done_clr. A set and a clear in the same cycle leave the flag set. irq = done_flag AND irq_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request (write of 1 to the go bit) |
| stop | input | 1 | Abort request (write of 0 to the go bit) |
| tx_word | input | DATA_W | Word to transmit |
| len_code | input | log2(DATA_W) | Bit count, 0 meaning DATA_W |
| tx_fall | input | 1 | Launch on falling (1) or rising (0) SCLK edges |
| rx_fall | input | 1 | Capture on falling (1) or rising (0) SCLK edges |
| lsb_first | input | 1 | Bit order select |
| cpol | input | 1 | SCLK idle level |
| divider | input | DIV_W | Half-period is divider+1 clocks |
| auto_sel | input | 1 | Automatic slave-select mode |
| sel_mask | input | SEL_N | Slave-select line choice |
| sel_active_high | input | 1 | Slave-select active level |
| irq_en | input | 1 | Interrupt enable |
| done_clr | input | 1 | Write-one clear of done_flag |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss | output | SEL_N | Slave-select lines |
| busy | output | 1 | Transaction running |
| done_pulse | output | 1 | One-cycle completion strobe |
| rx_word | output | DATA_W | Received word |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the control relations on every cycle. A start when idle always raises busy, and a stop always ends it without a done pulse. A done pulse lasts one cycle, follows a busy cycle and sets the flag. The flag survives until it is cleared. MOSI stays quiet when idle, and automatic selects stay inactive outside a transaction. The cycle-exact SCLK timing, the launch and capture edge pairings, the bit order, the zero extension and the insensitivity to a second start can only be shown by the bench. Its reference model predicts SCLK, MOSI and the select lines for every cycle of each transaction, and rebuilds the received word from the MISO values it drove.

// File: rtl/spi_master_engine.sv
module spi_master_engine #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int SEL_N  = 2,
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int IDX_W  = LEN_W + 1,
  localparam int ECNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len_code,
  input  logic              tx_fall,
  input  logic              rx_fall,
  input  logic              lsb_first,
  input  logic              cpol,
  input  logic [DIV_W-1:0]  divider,
  input  logic              auto_sel,
  input  logic [SEL_N-1:0]  sel_mask,
  input  logic              sel_active_high,
  input  logic              irq_en,
  input  logic              done_clr,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [SEL_N-1:0]  ss,
  output logic              busy,
  output logic              done_pulse,
  output logic [DATA_W-1:0] rx_word,
  output logic              done_flag,
  output logic              irq
);

  logic              busy_q, sclk_q, done_q, flag_q;
  logic              cpol_q, lsb_q, txf_q, rxf_q;
  logic [DIV_W-1:0]  cnt_q, div_q;
  logic [ECNT_W-1:0] ecnt_q;
  logic [IDX_W-1:0]  len_q, txi_q, rxi_q;
  logic [DATA_W-1:0] tx_q, rx_q;

  logic [IDX_W-1:0] len_eff, tx_pos, rx_pos;
  logic             tick, new_lvl, tx_edge, rx_edge, last, fin;
  logic [SEL_N-1:0] sel_act;

  assign len_eff = (len_code == '0) ? IDX_W'(DATA_W) : {1'b0, len_code};
  assign tick    = busy_q && (cnt_q == div_q);
  assign new_lvl = ~sclk_q;
  assign tx_edge = tick && (new_lvl != txf_q);
  assign rx_edge = tick && (new_lvl != rxf_q);
  assign last    = tick && ((ecnt_q + ECNT_W'(1)) == {len_q, 1'b0});
  assign fin     = busy_q && !stop && last;

  assign tx_pos = lsb_q ? txi_q : (len_q - txi_q - IDX_W'(1));
  assign rx_pos = lsb_q ? rxi_q : (len_q - rxi_q - IDX_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      cpol_q <= 1'b0;
      lsb_q  <= 1'b0;
      txf_q  <= 1'b0;
      rxf_q  <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      ecnt_q <= '0;
      len_q  <= '0;
      txi_q  <= '0;
      rxi_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          sclk_q <= cpol;
          cpol_q <= cpol;
          lsb_q  <= lsb_first;
          txf_q  <= tx_fall;
          rxf_q  <= rx_fall;
          cnt_q  <= '0;
          div_q  <= divider;
          ecnt_q <= '0;
          len_q  <= len_eff;
          txi_q  <= '0;
          rxi_q  <= '0;
          tx_q   <= tx_word;
          rx_q   <= '0;
        end
      end else if (stop) begin
        busy_q <= 1'b0;
      end else if (tick) begin
        cnt_q  <= '0;
        sclk_q <= new_lvl;
        ecnt_q <= ecnt_q + ECNT_W'(1);
        if (tx_edge) txi_q <= txi_q + IDX_W'(1);
        if (rx_edge) begin
          rx_q[rx_pos[LEN_W-1:0]] <= miso;
          rxi_q <= rxi_q + IDX_W'(1);
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (fin)      flag_q <= 1'b1;
    else if (done_clr) flag_q <= 1'b0;
  end

  assign sel_act    = auto_sel ? (sel_mask & {SEL_N{busy_q}}) : sel_mask;
  assign ss         = sel_active_high ? sel_act : ~sel_act;
  assign sclk       = busy_q ? sclk_q : cpol;
  assign mosi       = busy_q && (txi_q < len_q) && tx_q[tx_pos[LEN_W-1:0]];
  assign busy       = busy_q;
  assign done_pulse = done_q;
  assign rx_word    = rx_q;
  assign done_flag  = flag_q;
  assign irq        = flag_q & irq_en;

endmodule

// File: rtl/spi_master_engine_chk.sv
module spi_master_engine_chk #(
  parameter int SEL_N = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic             auto_sel,
  input logic             sel_active_high,
  input logic             irq_en,
  input logic             done_clr,
  input logic             mosi,
  input logic [SEL_N-1:0] ss,
  input logic             busy,
  input logic             done_pulse,
  input logic             done_flag,
  input logic             irq
);

  a_r9_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(busy) && !busy));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  a_r10_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (!busy && !done_pulse));

  a_r5_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  a_r11_auto_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_sel && !busy) |-> (ss == {SEL_N{~sel_active_high}}));

  a_r12_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done_flag);

  a_r12_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr) |=> done_flag);

  a_r12_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_flag && irq_en));

endmodule

bind spi_master_engine spi_master_engine_chk #(.SEL_N(SEL_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .auto_sel(auto_sel), .sel_active_high(sel_active_high),
  .irq_en(irq_en), .done_clr(done_clr), .mosi(mosi), .ss(ss),
  .busy(busy), .done_pulse(done_pulse), .done_flag(done_flag), .irq(irq)
);

// File: tb/spi_master_engine_test.sv
`timescale 1ns/1ps
module spi_master_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0;
  logic [31:0] tx_word = '0;
  logic [4:0]  len_code = '0;
  logic        tx_fall = 1'b0, rx_fall = 1'b0, lsb_first = 1'b0, cpol = 1'b0;
  logic [15:0] divider = '0;
  logic        auto_sel = 1'b1;
  logic [1:0]  sel_mask = 2'b01;
  logic        sel_active_high = 1'b0, irq_en = 1'b0, done_clr = 1'b0, miso = 1'b0;
  logic        sclk, mosi, busy, done_pulse, done_flag, irq;
  logic [1:0]  ss;
  logic [31:0] rx_word;

  int total = 0;
  int failed = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit hist [0:8191];

  always #2.5 clk = ~clk;

  spi_master_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tx_word(tx_word),
    .len_code(len_code), .tx_fall(tx_fall), .rx_fall(rx_fall),
    .lsb_first(lsb_first), .cpol(cpol), .divider(divider), .auto_sel(auto_sel),
    .sel_mask(sel_mask), .sel_active_high(sel_active_high), .irq_en(irq_en),
    .done_clr(done_clr), .miso(miso), .sclk(sclk), .mosi(mosi), .ss(ss),
    .busy(busy), .done_pulse(done_pulse), .rx_word(rx_word),
    .done_flag(done_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pos(input int i, input int len, input bit lsb);
    return lsb ? i : len - 1 - i;
  endfunction

  function automatic logic [1:0] ss_exp(input bit au, input logic [1:0] mk, input bit hi, input bit bz);
    logic [1:0] act;
    act = au ? (bz ? mk : 2'b00) : mk;
    return hi ? act : ~act;
  endfunction

  task automatic next_miso(input int t);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
    hist[t] = lfsr[0];
  endtask

  task automatic run_xfer(input logic [31:0] w, input logic [4:0] lc, input bit txf, input bit rxf,
                          input bit lsb, input bit cp, input int dv, input bit au,
                          input logic [1:0] mk, input bit hi, input bit poke, input string tag);
    int L = (lc == 0) ? 32 : int'(lc);
    int h = dv + 1;
    int n = 2 * L * h;
    int j;
    logic [31:0] exp_rx;
    logic [5:0] got6, exp6;
    tx_word = w; len_code = lc; tx_fall = txf; rx_fall = rxf; lsb_first = lsb;
    cpol = cp; divider = 16'(dv); auto_sel = au; sel_mask = mk; sel_active_high = hi;
    start = 1'b1;
    next_miso(0);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int t = 1; t <= n; t++) begin
      if (poke && t == 3) begin start = 1'b1; tx_word = ~w; divider = 16'(dv + 2); end
      if (poke && t == 4) begin start = 1'b0; tx_word = w; divider = 16'(dv); end
      next_miso(t);
      @(posedge clk); @(negedge clk);
      if (t < n) begin
        int e = t / h;
        int txc = 0;
        bit mo;
        for (int k = 1; k <= e; k++) if ((cp ^ k[0]) != txf) txc++;
        mo = (txc < L) ? w[pos(txc, L, lsb)] : 1'b0;
        exp6 = {1'b1, cp ^ e[0], mo, 1'b0, ss_exp(au, mk, hi, 1'b1)};
        got6 = {busy, sclk, mosi, done_pulse, ss};
        chk(got6 == exp6, {tag, " R2 R3 R5 R9 R11 {busy,sclk,mosi,done,ss}"}, 64'(got6), 64'(exp6));
      end
    end
    exp_rx = '0;
    j = 0;
    for (int k = 1; k <= 2 * L; k++) begin
      if ((cp ^ k[0]) != rxf) begin
        exp_rx[pos(j, L, lsb)] = hist[k * h];
        j++;
      end
    end
    exp6 = {1'b0, cp, 1'b0, 1'b1, ss_exp(au, mk, hi, 1'b0)};
    got6 = {busy, sclk, mosi, done_pulse, ss};
    chk(got6 == exp6, {tag, " R4 R9 end {busy,sclk,mosi,done,ss}"}, 64'(got6), 64'(exp6));
    chk(rx_word == exp_rx, {tag, " R6 R7 R8 rx_word"}, 64'(rx_word), 64'(exp_rx));
    chk(done_flag == 1'b1, {tag, " R12 flag set"}, 64'(done_flag), 64'd1);
    next_miso(n + 1);
    @(posedge clk); @(negedge clk);
    chk(done_pulse == 1'b0 && rx_word == exp_rx, {tag, " R8 R9 pulse drop, rx held"},
        {31'd0, done_pulse, rx_word}, {32'd0, exp_rx});
  endtask

  task automatic clr_flag;
    done_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    done_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done_pulse, done_flag, irq, mosi, sclk} == 6'b0, "R1 reset outputs",
        64'({busy, done_pulse, done_flag, irq, mosi, sclk}), 64'd0);
    chk(ss == 2'b11, "R11 auto idle inactive low", 64'(ss), 64'h3);

    run_xfer(32'h0000_00A5, 5'd8, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1, 2'b01, 1'b0, 1'b0, "mode0 8b");
    run_xfer(32'h1234_5678, 5'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2, 1'b1, 2'b11, 1'b1, 1'b0, "32b lsb cpol1");
    run_xfer(32'hFFFF_FFFF, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 2'b10, 1'b0, 1'b0, "1b rise/rise");
    run_xfer(32'h0000_0016, 5'd5, 1'b1, 1'b1, 1'b1, 1'b1, 3, 1'b1, 2'b01, 1'b1, 1'b1, "5b poke");
    run_xfer(32'h5A5A_C3C3, 5'd31, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 2'b10, 1'b0, 1'b0, "31b manual ss");

    auto_sel = 1'b0; sel_mask = 2'b10; sel_active_high = 1'b0;
    @(negedge clk);
    chk(ss == 2'b01, "R11 manual select idle", 64'(ss), 64'h1);
    sel_active_high = 1'b1;
    @(negedge clk);
    chk(ss == 2'b10, "R11 manual select active high", 64'(ss), 64'h2);

    irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0 && done_flag == 1'b1, "R12 irq masked", {62'd0, irq, done_flag}, 64'h1);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R12 irq enabled", 64'(irq), 64'h1);
    clr_flag();
    chk(done_flag == 1'b0 && irq == 1'b0, "R12 flag cleared", {62'd0, irq, done_flag}, 64'h0);

    auto_sel = 1'b1; sel_mask = 2'b01; sel_active_high = 1'b0;
    cpol = 1'b1; len_code = 5'd8; divider = 16'd1; tx_word = 32'hFF;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    stop = 1'b1;
    @(posedge clk); @(negedge clk);
    stop = 1'b0;
    chk({busy, sclk, done_pulse, ss} == {1'b0, 1'b1, 1'b0, 2'b11}, "R10 abort state",
        64'({busy, sclk, done_pulse, ss}), 64'(5'b01011));
    repeat (3) @(negedge clk);
    chk({busy, done_pulse, done_flag, mosi} == 4'b0, "R10 no completion after abort",
        64'({busy, done_pulse, done_flag, mosi}), 64'd0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule